// File: doc/BRIEF.md
# GPIO Interrupt Controller

A memory-mapped general-purpose I/O block for up to 32 pins. It has a word-wide register bus with a registered one-cycle read. Software sets each pin's output value and its output drive. It reads back the pad levels after a two-flop synchronizer.

Every pin has two independent interrupt sources. The level source is evaluated continuously from the synchronized input, an inversion bit and an enable bit, and it is never stored. The edge source stores detected rising or falling transitions in a sticky flag register, which software clears by writing ones. The flags are stored whether or not the edge enable is set. The enable only decides whether a stored flag counts as pending. All pending pins fold into one summary bit. A separate block-level enable gates that bit onto a single registered interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq` is 0, and both `pad_oe` and `pad_out` are all zeros.
- R2: A read is answered on `bus_rdata` in the cycle after the address is presented. Addresses outside the decoded set, and bits at or above NPIN in any register, read as zero.
- R3: The data-in register at 0x40 returns `pad_in` as sampled through two synchronizer flops. Writes to it have no effect.
- R4: Writing the data-out register (0x44) or the output-enable register (0x48) stores the low NPIN bits. `pad_oe` follows the output-enable register. `pad_out` carries a data-out bit only where that pin's enable is 1, and 0 elsewhere.
- R5: A pin's level term is (data-in XOR inversion bit at 0x50) AND enable bit at 0x54. An inversion bit of 1 makes the pin active-low. The term follows the input live and is not stored.
- R6: A bit of the edge-direction register at 0x64 selects falling detection when 1 and rising detection when 0. A detected edge sets that pin's flag in the register at 0x58, whatever the edge enable says.
- R7: Writing 1 to a bit of the flag register at 0x58 clears that flag, and writing 0 leaves it unchanged.
- R8: If a new edge and a clearing write hit the same flag in the same cycle, the flag stays set.
- R9: Bit 0 of the read-only summary register at 0x00 is the OR over all pins of (level term OR (flag AND edge enable at 0x5C)). Its other bits read zero.
- R10: `irq` is the registered value of summary bit 0 AND bit 0 of the block enable register at 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NPIN | Pad input levels |
| pad_out | output | NPIN | Pad output values, gated by enable |
| pad_oe | output | NPIN | Pad output enables |
| irq | output | 1 | Combined interrupt output |

## Verification
The edge detector and the write-one-to-clear path of the flag register can act on the same flag in one clock cycle. The bench first clears a flag. It then changes a pad input and places the clearing write so that its clock edge is the third one after the input change, which is the edge at which the detector loads the flag. The flag must read back as set afterwards. A later clearing write with no edge pending must clear it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int AW = 8;
    localparam int DW = 32;

    localparam logic [AW-1:0] OFS_STAT      = 8'h00;
    localparam logic [AW-1:0] OFS_IRQ_EN    = 8'h04;
    localparam logic [AW-1:0] OFS_PIN_IN    = 8'h40;
    localparam logic [AW-1:0] OFS_PIN_OUT   = 8'h44;
    localparam logic [AW-1:0] OFS_PIN_OE    = 8'h48;
    localparam logic [AW-1:0] OFS_LVL_INV   = 8'h50;
    localparam logic [AW-1:0] OFS_LVL_EN    = 8'h54;
    localparam logic [AW-1:0] OFS_EDGE_FLAG = 8'h58;
    localparam logic [AW-1:0] OFS_EDGE_EN   = 8'h5C;
    localparam logic [AW-1:0] OFS_EDGE_FALL = 8'h64;

    function automatic logic addr_known(input logic [AW-1:0] a);
        case (a)
            OFS_STAT, OFS_IRQ_EN, OFS_PIN_IN, OFS_PIN_OUT, OFS_PIN_OE,
            OFS_LVL_INV, OFS_LVL_EN, OFS_EDGE_FLAG, OFS_EDGE_EN,
            OFS_EDGE_FALL: return 1'b1;
            default:       return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pad_i,
    output logic [NPIN-1:0] pin_o,
    output logic [NPIN-1:0] prev_o
);
    typedef struct packed {
        logic [NPIN-1:0] s1;
        logic [NPIN-1:0] s2;
        logic [NPIN-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1   = pad_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pin_o  = sync_q.s2;
    assign prev_o = sync_q.prev;
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] prev_i,
    input  logic [NPIN-1:0] fall_i,
    input  logic [NPIN-1:0] clr_i,
    output logic [NPIN-1:0] flag_o
);
    logic [NPIN-1:0] hit;
    logic [NPIN-1:0] flag_d, flag_q;

    for (genvar i = 0; i < NPIN; i++) begin : g_det
        always_comb begin
            if (fall_i[i]) hit[i] = prev_i[i] & ~pin_i[i];
            else           hit[i] = pin_i[i] & ~prev_i[i];
        end
    end

    // a fresh edge overrides a clear in the same cycle
    always_comb flag_d = (flag_q & ~clr_i) | hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic            irq
);
    typedef struct packed {
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] oe;
        logic [NPIN-1:0] lvl_inv;
        logic [NPIN-1:0] lvl_en;
        logic [NPIN-1:0] edge_en;
        logic [NPIN-1:0] edge_fall;
        logic            irq_en;
        logic            irq;
        logic [DW-1:0]   rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPIN-1:0] pin_w, prev_w, flag_w, clr_w;
    logic [NPIN-1:0] lvl_term, edge_term;
    logic            any_pend;
    logic            wdata_unused;

    assign wdata_unused = ^bus_wdata;

    gpio_irq_sync #(.NPIN(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_in),
        .pin_o  (pin_w),
        .prev_o (prev_w)
    );

    gpio_irq_edge #(.NPIN(NPIN)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_w),
        .prev_i (prev_w),
        .fall_i (r_q.edge_fall),
        .clr_i  (clr_w),
        .flag_o (flag_w)
    );

    always_comb begin
        clr_w = (bus_we && bus_addr == OFS_EDGE_FLAG) ? bus_wdata[NPIN-1:0] : '0;
        lvl_term  = (pin_w ^ r_q.lvl_inv) & r_q.lvl_en;
        edge_term = flag_w & r_q.edge_en;
        any_pend  = |(lvl_term | edge_term);
    end

    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            case (bus_addr)
                OFS_IRQ_EN:    r_d.irq_en    = bus_wdata[0];
                OFS_PIN_OUT:   r_d.dout      = bus_wdata[NPIN-1:0];
                OFS_PIN_OE:    r_d.oe        = bus_wdata[NPIN-1:0];
                OFS_LVL_INV:   r_d.lvl_inv   = bus_wdata[NPIN-1:0];
                OFS_LVL_EN:    r_d.lvl_en    = bus_wdata[NPIN-1:0];
                OFS_EDGE_EN:   r_d.edge_en   = bus_wdata[NPIN-1:0];
                OFS_EDGE_FALL: r_d.edge_fall = bus_wdata[NPIN-1:0];
                default: ;
            endcase
        end
        r_d.irq = any_pend & r_q.irq_en;

        r_d.rdata = '0;
        case (bus_addr)
            OFS_STAT:      r_d.rdata[0]      = any_pend;
            OFS_IRQ_EN:    r_d.rdata[0]      = r_q.irq_en;
            OFS_PIN_IN:    r_d.rdata[NPIN-1:0] = pin_w;
            OFS_PIN_OUT:   r_d.rdata[NPIN-1:0] = r_q.dout;
            OFS_PIN_OE:    r_d.rdata[NPIN-1:0] = r_q.oe;
            OFS_LVL_INV:   r_d.rdata[NPIN-1:0] = r_q.lvl_inv;
            OFS_LVL_EN:    r_d.rdata[NPIN-1:0] = r_q.lvl_en;
            OFS_EDGE_FLAG: r_d.rdata[NPIN-1:0] = flag_w;
            OFS_EDGE_EN:   r_d.rdata[NPIN-1:0] = r_q.edge_en;
            OFS_EDGE_FALL: r_d.rdata[NPIN-1:0] = r_q.edge_fall;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign pad_oe    = r_q.oe;
    assign pad_out   = r_q.dout & r_q.oe;
    assign irq       = r_q.irq;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_we,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic            irq,
    input logic            irq_en,
    input logic [NPIN-1:0] pin,
    input logic [NPIN-1:0] prev,
    input logic [NPIN-1:0] fall,
    input logic [NPIN-1:0] flag,
    input logic [NPIN-1:0] dout
);
    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_EDGE_FLAG) |=> ((flag & $past(flag)) == $past(flag)));

    // R6
    rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin & ~prev & ~fall) != '0) |=>
        ((flag & $past(pin & ~prev & ~fall)) == $past(pin & ~prev & ~fall)));

    // R6
    fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pin & prev & fall) != '0) |=>
        ((flag & $past(~pin & prev & fall)) == $past(~pin & prev & fall)));

    // R4
    dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_PIN_OUT) |=> (dout == $past(bus_wdata[NPIN-1:0])));

    // R2
    unknown_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_known(bus_addr) |=> (bus_rdata == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .irq_en    (r_q.irq_en),
    .pin       (pin_w),
    .prev      (prev_w),
    .fall      (r_q.edge_fall),
    .flag      (flag_w),
    .dout      (r_q.dout)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
    import gpio_irq_pkg::*;

    localparam int NPIN = 16;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PMASK = (32'h1 << NPIN) - 1;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [7:0]      bus_addr = '0;
    logic            bus_we = 0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_out, pad_oe;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NPIN-1:0] m_dout = '0, m_oe = '0, m_inv = '0, m_len = '0;
    logic [NPIN-1:0] m_een = '0, m_fall = '0, m_flag = '0, m_pin = '0;
    logic            m_irqen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl #(.NPIN(NPIN)) u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic f_status();
        return |(((m_pin ^ m_inv) & m_len) | (m_flag & m_een));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_we = 0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic set_pad(input logic [NPIN-1:0] v);
        @(negedge clk);
        pad_in = v;
        m_flag = m_flag | (v & ~m_pin & ~m_fall) | (~v & m_pin & m_fall);
        m_pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        @(negedge clk);
        chk({tag, " R10 irq"}, {31'b0, irq}, {31'b0, f_status() & m_irqen});
        chk({tag, " R4 pad_oe"}, {16'b0, pad_oe}, {16'b0, m_oe});
        chk({tag, " R4 pad_out"}, {16'b0, pad_out}, {16'b0, m_dout & m_oe});
        rd(OFS_STAT, v);      chk({tag, " R9 status"}, v, {31'b0, f_status()});
        rd(OFS_IRQ_EN, v);    chk({tag, " R10 enable"}, v, {31'b0, m_irqen});
        rd(OFS_PIN_IN, v);    chk({tag, " R3 data-in"}, v, {16'b0, m_pin});
        rd(OFS_PIN_OUT, v);   chk({tag, " R4 data-out"}, v, {16'b0, m_dout});
        rd(OFS_PIN_OE, v);    chk({tag, " R4 oe"}, v, {16'b0, m_oe});
        rd(OFS_LVL_INV, v);   chk({tag, " R5 inv"}, v, {16'b0, m_inv});
        rd(OFS_LVL_EN, v);    chk({tag, " R5 len"}, v, {16'b0, m_len});
        rd(OFS_EDGE_FLAG, v); chk({tag, " R6 flag"}, v, {16'b0, m_flag});
        rd(OFS_EDGE_EN, v);   chk({tag, " R9 een"}, v, {16'b0, m_een});
        rd(OFS_EDGE_FALL, v); chk({tag, " R6 fall"}, v, {16'b0, m_fall});
    endtask

    task automatic mwr(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        case (a)
            OFS_IRQ_EN:    m_irqen = d[0];
            OFS_PIN_OUT:   m_dout = d[NPIN-1:0];
            OFS_PIN_OE:    m_oe = d[NPIN-1:0];
            OFS_LVL_INV:   m_inv = d[NPIN-1:0];
            OFS_LVL_EN:    m_len = d[NPIN-1:0];
            OFS_EDGE_EN:   m_een = d[NPIN-1:0];
            OFS_EDGE_FALL: m_fall = d[NPIN-1:0];
            OFS_EDGE_FLAG: m_flag = m_flag & ~d[NPIN-1:0];
            default: ;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0] wlist [8];
        void'($urandom(32'h5eed_0042));
        wlist = '{OFS_IRQ_EN, OFS_PIN_OUT, OFS_PIN_OE, OFS_LVL_INV,
                  OFS_LVL_EN, OFS_EDGE_EN, OFS_EDGE_FALL, OFS_EDGE_FLAG};
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check_all("R1 reset");

        // R4 outputs, R2 unused bits and unknown addresses
        mwr(OFS_PIN_OUT, 32'hFFFF_A5C3);
        mwr(OFS_PIN_OE, 32'hFFFF_0FF0);
        check_all("R4 drive");
        rd(OFS_PIN_OUT, v); chk("R2 upper bits", v & ~PMASK, 32'h0);
        rd(8'h08, v); chk("R2 unknown 0x08", v, 32'h0);
        rd(8'h60, v); chk("R2 unknown 0x60", v, 32'h0);
        rd(8'hFC, v); chk("R2 unknown 0xFC", v, 32'h0);

        // R3 data-in follows pad, write ignored
        set_pad(16'h00F0);
        wr(OFS_PIN_IN, 32'h0);
        rd(OFS_PIN_IN, v); chk("R3 data-in write ignored", v, 32'h00F0);
        check_all("R3 pad");

        // R5 level, live and not latched; inversion makes active-low
        mwr(OFS_IRQ_EN, 32'h1);
        mwr(OFS_LVL_EN, 32'h0008);
        set_pad(16'h00F8);
        check_all("R5 high");
        set_pad(16'h00F0);
        check_all("R5 released");
        mwr(OFS_LVL_INV, 32'h0008);
        check_all("R5 active-low");
        mwr(OFS_LVL_EN, 32'h0);
        mwr(OFS_LVL_INV, 32'h0);

        // R6 rising edge latched while masked
        set_pad(16'h00D0);
        set_pad(16'h00F0);
        check_all("R6 masked rise");
        mwr(OFS_EDGE_EN, 32'hFFFF);
        check_all("R9 enabled flag");
        // R7 write of zero keeps flag, write of one clears
        mwr(OFS_EDGE_FLAG, 32'h0);
        check_all("R7 zero write");
        mwr(OFS_EDGE_FLAG, 32'hFFFF);
        check_all("R7 clear");
        // R6 falling edge
        mwr(OFS_EDGE_FALL, 32'h0040);
        set_pad(16'h00B0);
        check_all("R6 fall");
        mwr(OFS_EDGE_FLAG, 32'hFFFF);

        // R9 status is read-only
        wr(OFS_STAT, 32'hFFFF_FFFF);
        check_all("R9 status write");

        // R8 edge and clear collide: clear lands on the edge that loads the flag
        @(negedge clk);
        pad_in = 16'h00B1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = OFS_EDGE_FLAG; bus_we = 1; bus_wdata = 32'h0001;
        @(negedge clk);
        bus_we = 0;
        m_pin = 16'h00B1;
        m_flag = m_flag | 16'h0001;
        rd(OFS_EDGE_FLAG, v); chk("R8 edge wins", v, 32'h0001);
        mwr(OFS_EDGE_FLAG, 32'h0001);
        rd(OFS_EDGE_FLAG, v); chk("R8 later clear", v, 32'h0);
        check_all("R8 after");

        // random mix
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 2) == 0) begin
                logic [NPIN-1:0] np;
                np = m_pin ^ NPIN'(1 << $urandom_range(0, NPIN-1));
                set_pad(np);
            end else begin
                mwr(wlist[$urandom_range(0, 7)], $urandom);
            end
            check_all("rand R9 R10");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule